// File: doc/BRIEF.md
# Programmable Local Trigger Timing Sequencer

This block is the per-channel timing engine of a detector front end. It runs on a 125 MHz clock, so one clock period is 8 ns. A start pulse from the channel discriminator launches a timed sequence that produces two one-cycle strobes. The first is a fast-trigger sample strobe at a delay that software programs. The second is a validation strobe whose time software also programs. Both delays take an 8-bit code, but each code has its own step size. The validation time also carries a fixed base of 2 µs.

The block also produces the channel inhibit. This is the external backplane inhibit, ORed with a local veto pulse when software has enabled the veto term. A veto request comes from shield suppression or from pileup detection. Each request fires a veto pulse whose width software selects in 100 ns units.

While inhibit is asserted, new starts are refused. Starts are also refused while a sequence is already running. Software reaches the block through a plain write port. When a sequence starts, it takes a private copy of its delay codes, so writes made during a run apply from the next start.

Top module: `trig_timing_seq`

## Requirements
- R1: A start is accepted when start_i is 1 at a clock edge, no sequence is running and inhibit_o is 0. Call the first cycle after that edge cycle 0. fast_stb_o is 1 in cycle F, where F is the fast code. One step of F is 8 ns, which is one clock.
- R2: val_stb_o is 1 in cycle (2000 + 40·V)/8, where V is the validation code. For V = 0 this is cycle 250.
- R3: When 2000 + 40·V exceeds 10000 ns (V above 200), the validation strobe comes in cycle 1250, which is 10 µs.
- R4: Each strobe lasts exactly one cycle. busy_o is 1 from cycle 0 through the validation cycle and is 0 in the cycle after it.
- R5: A start that arrives while busy_o or inhibit_o is 1 is ignored. It does not begin a sequence and does not disturb the one in progress.
- R6: If F is greater than the validation cycle, no fast strobe is produced. If F equals the validation cycle, both strobes are 1 in the same cycle.
- R7: inhibit_o = ext_inhibit_i OR (veto enable AND veto_o), where the veto enable is bit 0 of register 3.
- R8: A veto request (suppress_i or pileup_i equal to 1 at an edge while veto_o is 0) drives veto_o high from the next cycle for ceil(W·100/8) cycles. W is the veto code, so codes 1 to 5 give 13, 25, 38, 50 and 63 cycles. Code 0 acts as 1 and codes above 5 act as 5. Requests made while veto_o is 1 are ignored.
- R9: Writes to the fast or validation code made while busy_o is 1 do not change the current sequence. They apply from the next accepted start.
- R10: The write port has these registers: address 0 is the fast code, address 1 is the validation code, address 2 is the veto code, and address 3 bit 0 is the veto enable. A write takes effect at the edge where wr_en_i is 1. Reset clears all registers to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 125 MHz clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Start pulse from the discriminator |
| ext_inhibit_i | input | 1 | External backplane inhibit |
| suppress_i | input | 1 | Veto request from shield suppression |
| pileup_i | input | 1 | Veto request from pileup detection |
| wr_en_i | input | 1 | Register write enable |
| wr_addr_i | input | 2 | Register address |
| wr_data_i | input | 8 | Register write data |
| fast_stb_o | output | 1 | Fast-trigger sample strobe |
| val_stb_o | output | 1 | Validation strobe |
| busy_o | output | 1 | Sequence running |
| veto_o | output | 1 | Veto output pulse |
| inhibit_o | output | 1 | Combined inhibit |

## Verification
The fast range reaches 255 cycles and the shortest validation time is 250 cycles, so the two strobes can land in the same cycle. The bench forces this by setting fast code 250 with validation code 0, and expects both strobes in cycle 250. It also sets fast code 255 with validation code 0, and expects only the validation strobe. A second collision happens when a start meets an active veto or the external inhibit in the same cycle. The bench drives a start during each of these and judges the start refused when busy_o stays 0.

// File: rtl/tts_pkg.sv
package tts_pkg;

  // Fast strobe delay in clock cycles for a code.
  function automatic int fast_cycles(input int code, input int step_ns, input int clk_ns);
    return (code * step_ns) / clk_ns;
  endfunction

  // Validation delay in clock cycles: base plus steps, clamped to the ceiling.
  function automatic int val_cycles(input int code, input int base_ns, input int step_ns,
                                    input int max_ns, input int clk_ns);
    int ns;
    ns = base_ns + code * step_ns;
    if (ns > max_ns) ns = max_ns;
    return ns / clk_ns;
  endfunction

  // Veto pulse width in clock cycles, code clamped to 1..max_steps, rounded up.
  function automatic int veto_cycles(input int code, input int step_ns,
                                     input int max_steps, input int clk_ns);
    int k;
    k = (code < 1) ? 1 : ((code > max_steps) ? max_steps : code);
    return (k * step_ns + clk_ns - 1) / clk_ns;
  endfunction

endpackage

// File: rtl/tts_regs.sv
module tts_regs #(
  parameter int CODE_W = 8,
  parameter int ADDR_W = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [CODE_W-1:0] wr_data_i,
  output logic [CODE_W-1:0] fast_code_o,
  output logic [CODE_W-1:0] val_code_o,
  output logic [CODE_W-1:0] veto_code_o,
  output logic              veto_en_o
);
  localparam logic [ADDR_W-1:0] A_FAST = ADDR_W'(0);
  localparam logic [ADDR_W-1:0] A_VAL  = ADDR_W'(1);
  localparam logic [ADDR_W-1:0] A_VETO = ADDR_W'(2);
  localparam logic [ADDR_W-1:0] A_CTRL = ADDR_W'(3);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      fast_code_o <= '0;
      val_code_o  <= '0;
      veto_code_o <= '0;
      veto_en_o   <= 1'b0;
    end else if (wr_en_i) begin
      case (wr_addr_i)
        A_FAST:  fast_code_o <= wr_data_i;
        A_VAL:   val_code_o  <= wr_data_i;
        A_VETO:  veto_code_o <= wr_data_i;
        A_CTRL:  veto_en_o   <= wr_data_i[0];
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/tts_veto.sv
module tts_veto #(
  parameter int CODE_W         = 8,
  parameter int CLK_NS         = 8,
  parameter int VETO_STEP_NS   = 100,
  parameter int VETO_MAX_STEPS = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              request_i,
  input  logic [CODE_W-1:0] code_i,
  output logic              launch_o,
  output logic              veto_o
);
  import tts_pkg::*;
  localparam int MAX_CYC = (VETO_MAX_STEPS * VETO_STEP_NS + CLK_NS - 1) / CLK_NS;
  localparam int VCNT_W  = $clog2(MAX_CYC + 1);

  logic [VCNT_W-1:0] left;

  assign veto_o   = (left != '0);
  assign launch_o = request_i && !veto_o;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      left <= '0;
    end else if (launch_o) begin
      left <= VCNT_W'(veto_cycles(int'(code_i), VETO_STEP_NS, VETO_MAX_STEPS, CLK_NS));
    end else if (veto_o) begin
      left <= left - 1'b1;
    end
  end
endmodule

// File: rtl/tts_seq.sv
module tts_seq #(
  parameter int CODE_W       = 8,
  parameter int CNT_W        = 11,
  parameter int CLK_NS       = 8,
  parameter int FAST_STEP_NS = 8,
  parameter int VAL_BASE_NS  = 2000,
  parameter int VAL_STEP_NS  = 40,
  parameter int VAL_MAX_NS   = 10000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic              inhibit_i,
  input  logic [CODE_W-1:0] fast_code_i,
  input  logic [CODE_W-1:0] val_code_i,
  output logic              accept_o,
  output logic              fast_stb_o,
  output logic              val_stb_o,
  output logic              busy_o
);
  import tts_pkg::*;

  logic             running;
  logic [CNT_W-1:0] elapsed;
  logic [CNT_W-1:0] fast_tgt;
  logic [CNT_W-1:0] val_tgt;

  assign accept_o   = start_i && !running && !inhibit_i;
  assign busy_o     = running;
  // The counter stops at val_tgt, so a fast target beyond it never matches.
  assign fast_stb_o = running && (elapsed == fast_tgt);
  assign val_stb_o  = running && (elapsed == val_tgt);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      running  <= 1'b0;
      elapsed  <= '0;
      fast_tgt <= '0;
      val_tgt  <= '0;
    end else if (accept_o) begin
      running  <= 1'b1;
      elapsed  <= '0;
      fast_tgt <= CNT_W'(fast_cycles(int'(fast_code_i), FAST_STEP_NS, CLK_NS));
      val_tgt  <= CNT_W'(val_cycles(int'(val_code_i), VAL_BASE_NS, VAL_STEP_NS,
                                    VAL_MAX_NS, CLK_NS));
    end else if (running) begin
      if (val_stb_o) running <= 1'b0;
      else           elapsed <= elapsed + 1'b1;
    end
  end
endmodule

// File: rtl/trig_timing_seq.sv
module trig_timing_seq #(
  parameter int CODE_W         = 8,
  parameter int ADDR_W         = 2,
  parameter int CLK_NS         = 8,
  parameter int FAST_STEP_NS   = 8,
  parameter int VAL_BASE_NS    = 2000,
  parameter int VAL_STEP_NS    = 40,
  parameter int VAL_MAX_NS     = 10000,
  parameter int VETO_STEP_NS   = 100,
  parameter int VETO_MAX_STEPS = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic              ext_inhibit_i,
  input  logic              suppress_i,
  input  logic              pileup_i,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [CODE_W-1:0] wr_data_i,
  output logic              fast_stb_o,
  output logic              val_stb_o,
  output logic              busy_o,
  output logic              veto_o,
  output logic              inhibit_o
);
  localparam int FAST_MAX_CYC = ((2 ** CODE_W) - 1) * FAST_STEP_NS / CLK_NS;
  localparam int VAL_MAX_CYC  = VAL_MAX_NS / CLK_NS;
  localparam int TOP_CYC      = (FAST_MAX_CYC > VAL_MAX_CYC) ? FAST_MAX_CYC : VAL_MAX_CYC;
  localparam int CNT_W        = $clog2(TOP_CYC + 1);

  logic [CODE_W-1:0] fast_code, val_code, veto_code;
  logic              veto_en;
  logic              seq_accept;   // start taken this cycle
  logic              veto_launch;  // veto pulse begins next cycle

  tts_regs #(.CODE_W(CODE_W), .ADDR_W(ADDR_W)) u_regs (
    .clk(clk), .rst_n(rst_n),
    .wr_en_i(wr_en_i), .wr_addr_i(wr_addr_i), .wr_data_i(wr_data_i),
    .fast_code_o(fast_code), .val_code_o(val_code),
    .veto_code_o(veto_code), .veto_en_o(veto_en)
  );

  tts_veto #(
    .CODE_W(CODE_W), .CLK_NS(CLK_NS),
    .VETO_STEP_NS(VETO_STEP_NS), .VETO_MAX_STEPS(VETO_MAX_STEPS)
  ) u_veto (
    .clk(clk), .rst_n(rst_n),
    .request_i(suppress_i || pileup_i), .code_i(veto_code),
    .launch_o(veto_launch), .veto_o(veto_o)
  );

  assign inhibit_o = ext_inhibit_i || (veto_en && veto_o);

  tts_seq #(
    .CODE_W(CODE_W), .CNT_W(CNT_W), .CLK_NS(CLK_NS), .FAST_STEP_NS(FAST_STEP_NS),
    .VAL_BASE_NS(VAL_BASE_NS), .VAL_STEP_NS(VAL_STEP_NS), .VAL_MAX_NS(VAL_MAX_NS)
  ) u_seq (
    .clk(clk), .rst_n(rst_n),
    .start_i(start_i), .inhibit_i(inhibit_o),
    .fast_code_i(fast_code), .val_code_i(val_code),
    .accept_o(seq_accept), .fast_stb_o(fast_stb_o),
    .val_stb_o(val_stb_o), .busy_o(busy_o)
  );
endmodule

// File: rtl/trig_timing_seq_chk.sv
module trig_timing_seq_chk (
  input logic clk,
  input logic rst_n,
  input logic start_i,
  input logic ext_inhibit_i,
  input logic inhibit_o,
  input logic busy_o,
  input logic fast_stb_o,
  input logic val_stb_o,
  input logic veto_o,
  input logic accept,
  input logic veto_launch
);
  a_r5_start_refused: assert property (@(posedge clk) disable iff (!rst_n)
    (start_i && (busy_o || inhibit_o)) |-> !accept);
  a_r5_accept_runs: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> busy_o);
  a_r4_val_one_cycle_then_idle: assert property (@(posedge clk) disable iff (!rst_n)
    val_stb_o |=> (!val_stb_o && !busy_o));
  a_r4_fast_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    fast_stb_o |=> !fast_stb_o);
  a_r1_fast_inside_run: assert property (@(posedge clk) disable iff (!rst_n)
    fast_stb_o |-> busy_o);
  a_r7_ext_forces_inhibit: assert property (@(posedge clk) disable iff (!rst_n)
    ext_inhibit_i |-> inhibit_o);
  a_r7_quiet_no_inhibit: assert property (@(posedge clk) disable iff (!rst_n)
    (!ext_inhibit_i && !veto_o) |-> !inhibit_o);
  a_r8_veto_follows_launch: assert property (@(posedge clk) disable iff (!rst_n)
    veto_launch |=> veto_o);
  a_r8_no_retrigger: assert property (@(posedge clk) disable iff (!rst_n)
    veto_launch |-> !veto_o);
endmodule

bind trig_timing_seq trig_timing_seq_chk u_chk (
  .clk(clk), .rst_n(rst_n), .start_i(start_i), .ext_inhibit_i(ext_inhibit_i),
  .inhibit_o(inhibit_o), .busy_o(busy_o), .fast_stb_o(fast_stb_o),
  .val_stb_o(val_stb_o), .veto_o(veto_o), .accept(seq_accept),
  .veto_launch(veto_launch)
);

// File: tb/trig_timing_seq_bench.sv
`timescale 1ns/1ps
module trig_timing_seq_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start_i = 0, ext_inhibit_i = 0, suppress_i = 0, pileup_i = 0;
  logic wr_en_i = 0;
  logic [1:0] wr_addr_i = '0;
  logic [7:0] wr_data_i = '0;
  logic fast_stb_o, val_stb_o, busy_o, veto_o, inhibit_o;

  int total = 0;
  int bad = 0;
  bit done = 0;

  always #4 clk = ~clk;

  trig_timing_seq u_trig_timing_seq (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .ext_inhibit_i(ext_inhibit_i),
    .suppress_i(suppress_i), .pileup_i(pileup_i), .wr_en_i(wr_en_i),
    .wr_addr_i(wr_addr_i), .wr_data_i(wr_data_i), .fast_stb_o(fast_stb_o),
    .val_stb_o(val_stb_o), .busy_o(busy_o), .veto_o(veto_o), .inhibit_o(inhibit_o)
  );

  // Expected values restated from the requirements, in nanoseconds first.
  function automatic int exp_val(input int v);
    int t_ns;
    t_ns = 2000 + v * 40;
    if (t_ns > 10000) t_ns = 10000;
    return t_ns / 8;
  endfunction

  function automatic int exp_fast(input int f, input int v);
    if (f > exp_val(v)) return -1;
    return (f * 8) / 8;
  endfunction

  function automatic int exp_veto(input int w);
    int table_ns[6] = '{100, 100, 200, 300, 400, 500};
    int ns;
    ns = (w > 5) ? 500 : table_ns[w];
    return (ns % 8 == 0) ? ns / 8 : ns / 8 + 1;
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%0d exp=%0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    wr_en_i = 1; wr_addr_i = a; wr_data_i = d;
    @(negedge clk);
    wr_en_i = 0;
  endtask

  // kind: 0 plain, 1 write a/d at cycle 10, 2 extra start at cycle 20
  task automatic run_seq(input int ef, input int ev, input int kind,
                         input logic [1:0] a, input logic [7:0] d, input string tag);
    int gf = -1, gv = -1, nf = 0, nv = 0;
    bit busy_after = 1;
    @(negedge clk);
    start_i = 1;
    @(negedge clk);
    start_i = 0;
    check(busy_o == 1'b1, {tag, " R5 start accepted"}, busy_o, 1);
    for (int k = 0; k < 1400; k++) begin
      if (fast_stb_o) begin if (gf < 0) gf = k; nf++; end
      if (val_stb_o)  begin if (gv < 0) gv = k; nv++; end
      if (gv >= 0 && k == gv + 1) begin busy_after = busy_o; break; end
      if (kind == 1 && k == 10) begin wr_en_i = 1; wr_addr_i = a; wr_data_i = d; end
      if (kind == 1 && k == 11) wr_en_i = 0;
      if (kind == 2 && k == 20) start_i = 1;
      if (kind == 2 && k == 21) start_i = 0;
      @(negedge clk);
    end
    check(gf == ef, {tag, " R1/R6 fast strobe cycle"}, gf, ef);
    check(gv == ev, {tag, " R2/R3 validation cycle"}, gv, ev);
    check(nf <= 1 && nv == 1, {tag, " R4 strobe width"}, nf * 10 + nv, (ef < 0) ? 1 : 11);
    check(busy_after == 1'b0, {tag, " R4 idle after validation"}, busy_after, 0);
    repeat (3) @(negedge clk);
    check(busy_o == 1'b0, {tag, " R5 no extra run"}, busy_o, 0);
  endtask

  task automatic veto_meas(input int w, input bit en, input bit use_pileup,
                           input bit retrig, input string tag);
    int n = 0, inh_err = 0;
    @(negedge clk);
    if (use_pileup) pileup_i = 1; else suppress_i = 1;
    @(negedge clk);
    pileup_i = 0; suppress_i = 0;
    while (veto_o && n < 200) begin
      if (inhibit_o != en) inh_err++;
      if (retrig && n == 5) suppress_i = 1;
      if (retrig && n == 6) suppress_i = 0;
      n++;
      @(negedge clk);
    end
    suppress_i = 0;
    check(n == exp_veto(w), {tag, " R8 veto width"}, n, exp_veto(w));
    check(inh_err == 0, {tag, " R7 inhibit during veto"}, inh_err, 0);
    @(negedge clk);
    check(veto_o == 1'b0, {tag, " R8 veto ends"}, veto_o, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog act=0 exp=1");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    int seed;
    int f, v;
    seed = $urandom(32'd4242);
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R10 reset state
    check({fast_stb_o, val_stb_o, busy_o, veto_o, inhibit_o} == 5'b0,
          "R10 reset outputs", {fast_stb_o, val_stb_o, busy_o, veto_o, inhibit_o}, 0);
    run_seq(0, 250, 0, 2'd0, 8'd0, "R10 reset codes");

    // R1/R2 directed
    wr(2'd0, 8'd17); wr(2'd1, 8'd3);
    run_seq(17, exp_val(3), 0, 2'd0, 8'd0, "R1 basic");
    // R3 clamp boundary
    wr(2'd0, 8'd0); wr(2'd1, 8'd200);
    run_seq(0, 1250, 0, 2'd0, 8'd0, "R3 code 200");
    wr(2'd1, 8'd201);
    run_seq(0, 1250, 0, 2'd0, 8'd0, "R3 code 201");
    wr(2'd1, 8'd255);
    run_seq(0, 1250, 0, 2'd0, 8'd0, "R3 code 255");
    // R6 collision and overrun
    wr(2'd0, 8'd250); wr(2'd1, 8'd0);
    run_seq(250, 250, 0, 2'd0, 8'd0, "R6 same cycle");
    wr(2'd0, 8'd255);
    run_seq(-1, 250, 0, 2'd0, 8'd0, "R6 fast beyond validation");
    wr(2'd0, 8'd249);
    run_seq(249, 250, 0, 2'd0, 8'd0, "R6 fast one before");
    // R9 writes during run
    wr(2'd0, 8'd40); wr(2'd1, 8'd1);
    run_seq(40, exp_val(1), 1, 2'd0, 8'd90, "R9 fast write mid-run");
    run_seq(90, exp_val(1), 1, 2'd1, 8'd60, "R9 val write mid-run");
    run_seq(90, exp_val(60), 0, 2'd0, 8'd0, "R9 new codes apply");
    // R5 start while busy
    wr(2'd0, 8'd5); wr(2'd1, 8'd0);
    run_seq(5, 250, 2, 2'd0, 8'd0, "R5 start while busy");

    // R5/R7 external inhibit
    @(negedge clk);
    ext_inhibit_i = 1; start_i = 1;
    @(negedge clk);
    start_i = 0;
    check(inhibit_o == 1'b1, "R7 external inhibit", inhibit_o, 1);
    @(negedge clk);
    check(busy_o == 1'b0, "R5 start under inhibit", busy_o, 0);
    ext_inhibit_i = 0;
    @(negedge clk);

    // R8 veto widths, veto disabled
    veto_meas(0, 0, 0, 0, "R8 code 0");
    for (int w = 1; w <= 5; w++) begin
      wr(2'd2, 8'(w));
      veto_meas(w, 0, w[0], 0, "R8 code");
    end
    wr(2'd2, 8'd9);
    veto_meas(9, 0, 0, 0, "R8 code 9");
    wr(2'd2, 8'd2);
    veto_meas(2, 0, 0, 1, "R8 retrigger ignored");
    // R7 veto enabled
    wr(2'd3, 8'd1);
    veto_meas(2, 1, 1, 0, "R7 enabled");
    // R5 start during an enabled veto
    @(negedge clk);
    suppress_i = 1;
    @(negedge clk);
    suppress_i = 0; start_i = 1;
    @(negedge clk);
    start_i = 0;
    check(busy_o == 1'b0, "R5 start during veto", busy_o, 0);
    check(inhibit_o == 1'b1, "R7 veto inhibits", inhibit_o, 1);
    repeat (40) @(negedge clk);
    wr(2'd3, 8'd0);

    // Random runs, R1 R2 R3 R6
    for (int i = 0; i < 24; i++) begin
      f = int'($urandom % 256);
      v = int'($urandom % 256);
      wr(2'd0, 8'(f)); wr(2'd1, 8'(v));
      run_seq(exp_fast(f, v), exp_val(v), 0, 2'd0, 8'd0, "R2 random");
    end

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule